// File: doc/BRIEF.md
# Physical Register Free List

This block hands out free physical register indices to the rename stage of an out-of-order core. Each cycle a group of rename slots may each ask for one destination register. The block shows, in the same cycle, the index each slot would receive and a single flag saying whether the whole group can be served. The consumer then confirms the allocation with a separate commit input. It drives that input only when its other resources, such as a second free list for another register class, and the downstream stage are also ready. The consumer clears a slot's request when the instruction in it has no destination, for example an integer write to the hard-wired zero register.

Free indices live in a circular queue with an allocation pointer (head) and a release pointer (tail). Committing instructions return the index that their destination was mapped to before them, and these are appended at the tail. On misprediction recovery a walk input moves the head back by the number of rolled-back instructions that own a destination of this class, which returns their speculative registers to the free pool. A walk wins over any allocation in the same cycle. A flush input blocks allocation for the cycle in which it is raised.

Top module: `preg_free_list`

## Requirements
- R1: After reset the queue is full and holds the indices ARCH_REGS up to NUM_PREGS-1 in ascending order, so with every slot requesting, slot i shows ARCH_REGS+i and can_alloc_o is high.
- R2: Requesting slots take consecutive free entries in slot order starting at the head. A slot that does not request takes no entry, so the next requesting slot gets the entry it would have taken. The indices are valid in the same cycle as the requests.
- R3: can_alloc_o is high exactly when flush_i is low and the number of free entries is at least the number of slots with alloc_req_i set.
- R4: Entries are consumed at a clock edge only when do_alloc_i and can_alloc_o are both high and walk_valid_i is low. Otherwise the head holds, and in the next cycle the same requests see the same indices.
- R5: When walk_valid_i is high, the head moves back by walk_cnt_i at the clock edge. This overrides any allocation requested in the same cycle.
- R6: Each commit slot with rel_en_i set appends its rel_idx_i at the tail, in commit-slot order, and several releases in one cycle are all accepted. A released index is handed out only after every entry that was free before it.
- R7: While flush_i is high, can_alloc_o is low and no allocation takes effect, but releases in that cycle are still accepted.
- R8: No physical index is handed out while it is still live, that is, allocated and not yet released or walked back.
- R9: Allocations followed by walks of the same total count restore the head exactly, so the same requests then see the same indices as before.
- R10: Both pointers wrap around the queue, and allocation and release stay correct after many times the queue depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Blocks allocation in this cycle |
| alloc_req_i | input | SLOTS | One request bit per rename slot |
| do_alloc_i | input | 1 | Commits the requested allocation at the edge |
| can_alloc_o | output | 1 | All requesting slots can be served |
| alloc_idx_o | output | SLOTS x log2(NUM_PREGS) | Index offered to each slot |
| walk_valid_i | input | 1 | Rollback step valid |
| walk_cnt_i | input | log2(RELS+1) | Number of entries to move the head back |
| rel_en_i | input | RELS | Release enable per commit slot |
| rel_idx_i | input | RELS x log2(NUM_PREGS) | Index released by each commit slot |

## Verification
can_alloc_o and alloc_idx_o are combinational, so they answer the requests, flush and pointer state of the same cycle. The effect of do_alloc_i, walk_valid_i and rel_en_i shows one rising edge later, as changed indices or a changed flag. The bench therefore changes inputs on the falling edge, samples outputs 1 ns later in the same cycle, and advances its reference queue only after the next rising edge. Every check of a pointer move is thus made against the indices offered in the following cycle.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

   // Action taken on the allocation pointer at the next edge.
   typedef enum logic [1:0] {
      HEAD_HOLD  = 2'd0,
      HEAD_ALLOC = 2'd1,
      HEAD_WALK  = 2'd2
   } head_op_e;

   // True when v is a nonzero power of two.
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pfl_prefix_count.sv
// Exclusive prefix count of a bit vector: offs_o[i] is the number of set
// bits below position i; total_o is the number of all set bits.
module pfl_prefix_count #(
   parameter int unsigned W      = 4,
   parameter int unsigned CW     = $clog2(W + 1),
   parameter bit          RIPPLE = 1'b1
) (
   input  logic [W-1:0]         bits_i,
   output logic [W-1:0][CW-1:0] offs_o,
   output logic [CW-1:0]        total_o
);

   if (RIPPLE) begin : g_ripple
      // Serial accumulation: smallest area, depth grows with W.
      always_comb begin
         logic [CW-1:0] acc;
         acc = '0;
         for (int i = 0; i < W; i++) begin
            offs_o[i] = acc;
            acc       = acc + CW'(bits_i[i]);
         end
         total_o = acc;
      end
   end else begin : g_parallel
      // Independent population count per slot: shallow, more adders.
      for (genvar i = 0; i < W; i++) begin : g_slot
         if (i == 0) begin : g_first
            assign offs_o[i] = '0;
         end else begin : g_rest
            assign offs_o[i] = CW'($countones(bits_i[i-1:0]));
         end
      end
      assign total_o = CW'($countones(bits_i));
   end

endmodule

// File: rtl/pfl_ptr_ctrl.sv
// Head/tail pointer pair with a wrap bit, free count and the group grant.
module pfl_ptr_ctrl
   import pfl_pkg::*;
#(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned ACW   = 3,
   parameter int unsigned RCW   = 3,
   parameter int unsigned WCW   = 3,
   localparam int unsigned PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush_i,
   input  logic [ACW-1:0] req_cnt_i,
   input  logic          do_alloc_i,
   input  logic          walk_valid_i,
   input  logic [WCW-1:0] walk_cnt_i,
   input  logic [RCW-1:0] rel_cnt_i,
   output logic          can_alloc_o,
   output logic [PW:0]   head_q,
   output logic [PW:0]   tail_q
);

   localparam logic [PW:0] FULL_CNT = (PW + 1)'(DEPTH);

   logic [PW:0] free_cnt;
   logic [PW:0] head_d;
   logic [PW:0] tail_d;
   head_op_e    op;

   assign free_cnt    = tail_q - head_q;
   assign can_alloc_o = !flush_i && (free_cnt >= (PW + 1)'(req_cnt_i));

   // Walk first, then a confirmed grant, otherwise hold.
   always_comb begin
      if (walk_valid_i) begin
         op = HEAD_WALK;
      end else if (do_alloc_i && can_alloc_o) begin
         op = HEAD_ALLOC;
      end else begin
         op = HEAD_HOLD;
      end
   end

   always_comb begin
      case (op)
         HEAD_WALK:  head_d = head_q - (PW + 1)'(walk_cnt_i);
         HEAD_ALLOC: head_d = head_q + (PW + 1)'(req_cnt_i);
         default:    head_d = head_q;
      endcase
   end

   assign tail_d = tail_q + (PW + 1)'(rel_cnt_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= FULL_CNT;
      end else begin
         head_q <= head_d;
         tail_q <= tail_d;
      end
   end

endmodule

// File: rtl/pfl_store.sv
// Circular storage of free indices: many read ports at head offsets,
// many write ports at tail offsets.
module pfl_store #(
   parameter int unsigned DEPTH     = 32,
   parameter int unsigned IDX_W     = 6,
   parameter int unsigned RD_PORTS  = 4,
   parameter int unsigned WR_PORTS  = 4,
   parameter int unsigned FILL_BASE = 32,
   parameter int unsigned ACW       = 3,
   parameter int unsigned RCW       = 3,
   localparam int unsigned PW       = $clog2(DEPTH)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [PW-1:0]                      rd_base_i,
   input  logic [RD_PORTS-1:0][ACW-1:0]       rd_offs_i,
   output logic [RD_PORTS-1:0][IDX_W-1:0]     rd_data_o,
   input  logic [PW-1:0]                      wr_base_i,
   input  logic [WR_PORTS-1:0]                wr_en_i,
   input  logic [WR_PORTS-1:0][RCW-1:0]       wr_offs_i,
   input  logic [WR_PORTS-1:0][IDX_W-1:0]     wr_data_i
);

   logic [IDX_W-1:0] cells_q [DEPTH];
   logic [PW-1:0]    rd_addr [RD_PORTS];
   logic [PW-1:0]    wr_addr [WR_PORTS];

   for (genvar i = 0; i < RD_PORTS; i++) begin : g_rd
      assign rd_addr[i]   = rd_base_i + PW'(rd_offs_i[i]);
      assign rd_data_o[i] = cells_q[rd_addr[i]];
   end

   for (genvar j = 0; j < WR_PORTS; j++) begin : g_wr
      assign wr_addr[j] = wr_base_i + PW'(wr_offs_i[j]);
   end

   // Enabled ports are compacted by the offsets, so their addresses differ.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) begin
            cells_q[k] <= IDX_W'(FILL_BASE + k);
         end
      end else begin
         for (int j = 0; j < WR_PORTS; j++) begin
            if (wr_en_i[j]) begin
               cells_q[wr_addr[j]] <= wr_data_i[j];
            end
         end
      end
   end

endmodule

// File: rtl/preg_free_list.sv
module preg_free_list #(
   parameter int unsigned NUM_PREGS     = 64,
   parameter int unsigned ARCH_REGS     = 32,
   parameter int unsigned SLOTS         = 4,
   parameter int unsigned RELS          = 4,
   parameter bit          PREFIX_RIPPLE = 1'b1
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         flush_i,
   input  logic [SLOTS-1:0]                             alloc_req_i,
   input  logic                                         do_alloc_i,
   output logic                                         can_alloc_o,
   output logic [SLOTS-1:0][$clog2(NUM_PREGS)-1:0]      alloc_idx_o,
   input  logic                                         walk_valid_i,
   input  logic [$clog2(RELS+1)-1:0]                    walk_cnt_i,
   input  logic [RELS-1:0]                              rel_en_i,
   input  logic [RELS-1:0][$clog2(NUM_PREGS)-1:0]       rel_idx_i
);

   localparam int unsigned IDX_W = $clog2(NUM_PREGS);
   localparam int unsigned DEPTH = NUM_PREGS - ARCH_REGS;
   localparam int unsigned PW    = $clog2(DEPTH);
   localparam int unsigned ACW   = $clog2(SLOTS + 1);
   localparam int unsigned RCW   = $clog2(RELS + 1);

   // Elaboration-time parameter checks.
   if (NUM_PREGS <= ARCH_REGS) begin : g_chk_regs
      $error("free list: NUM_PREGS must exceed ARCH_REGS");
   end
   if (!pfl_pkg::is_pow2(DEPTH) || DEPTH < 2) begin : g_chk_depth
      $error("free list: NUM_PREGS-ARCH_REGS must be a power of two >= 2");
   end
   if (SLOTS < 1 || SLOTS > DEPTH) begin : g_chk_slots
      $error("free list: SLOTS must be between 1 and the queue depth");
   end
   if (RELS < 1 || RELS > DEPTH) begin : g_chk_rels
      $error("free list: RELS must be between 1 and the queue depth");
   end

   logic [SLOTS-1:0][ACW-1:0] req_offs;
   logic [ACW-1:0]            req_total;
   logic [RELS-1:0][RCW-1:0]  rel_offs;
   logic [RCW-1:0]            rel_total;
   logic [PW:0]               head_q;
   logic [PW:0]               tail_q;

   pfl_prefix_count #(
      .W      (SLOTS),
      .CW     (ACW),
      .RIPPLE (PREFIX_RIPPLE)
   ) u_req_pfx (
      .bits_i  (alloc_req_i),
      .offs_o  (req_offs),
      .total_o (req_total)
   );

   pfl_prefix_count #(
      .W      (RELS),
      .CW     (RCW),
      .RIPPLE (PREFIX_RIPPLE)
   ) u_rel_pfx (
      .bits_i  (rel_en_i),
      .offs_o  (rel_offs),
      .total_o (rel_total)
   );

   pfl_ptr_ctrl #(
      .DEPTH (DEPTH),
      .ACW   (ACW),
      .RCW   (RCW),
      .WCW   (RCW)
   ) u_ptr (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush_i      (flush_i),
      .req_cnt_i    (req_total),
      .do_alloc_i   (do_alloc_i),
      .walk_valid_i (walk_valid_i),
      .walk_cnt_i   (walk_cnt_i),
      .rel_cnt_i    (rel_total),
      .can_alloc_o  (can_alloc_o),
      .head_q       (head_q),
      .tail_q       (tail_q)
   );

   pfl_store #(
      .DEPTH     (DEPTH),
      .IDX_W     (IDX_W),
      .RD_PORTS  (SLOTS),
      .WR_PORTS  (RELS),
      .FILL_BASE (ARCH_REGS),
      .ACW       (ACW),
      .RCW       (RCW)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_base_i (head_q[PW-1:0]),
      .rd_offs_i (req_offs),
      .rd_data_o (alloc_idx_o),
      .wr_base_i (tail_q[PW-1:0]),
      .wr_en_i   (rel_en_i),
      .wr_offs_i (rel_offs),
      .wr_data_i (rel_idx_i)
   );

endmodule

// File: rtl/pfl_checker.sv
module pfl_checker #(
   parameter int unsigned NUM_PREGS = 64,
   parameter int unsigned ARCH_REGS = 32,
   parameter int unsigned SLOTS     = 4,
   parameter int unsigned RELS      = 4
) (
   input logic                                    clk,
   input logic                                    rst_n,
   input logic                                    flush_i,
   input logic [SLOTS-1:0]                        alloc_req_i,
   input logic                                    do_alloc_i,
   input logic                                    can_alloc_o,
   input logic [SLOTS-1:0][$clog2(NUM_PREGS)-1:0] alloc_idx_o,
   input logic                                    walk_valid_i,
   input logic [$clog2(RELS+1)-1:0]               walk_cnt_i,
   input logic [RELS-1:0]                         rel_en_i,
   input logic [$clog2(NUM_PREGS-ARCH_REGS):0]    head_q,
   input logic [$clog2(NUM_PREGS-ARCH_REGS):0]    tail_q
);

   localparam int unsigned DEPTH = NUM_PREGS - ARCH_REGS;
   localparam int unsigned PW    = $clog2(DEPTH);

   // R4: no confirmed grant and no walk leaves the head in place.
   p_head_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!walk_valid_i && !(do_alloc_i && can_alloc_o)) |=> $stable(head_q));

   // R4: a confirmed grant advances the head by the request count.
   p_head_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!walk_valid_i && do_alloc_i && can_alloc_o)
      |=> ((head_q - $past(head_q)) == (PW + 1)'($countones($past(alloc_req_i)))));

   // R5: a walk moves the head back by its count, whatever else is asked.
   p_walk_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
      walk_valid_i |=> (($past(head_q) - head_q) == (PW + 1)'($past(walk_cnt_i))));

   // R6: every enabled release is appended.
   p_tail_append_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((tail_q - $past(tail_q)) == (PW + 1)'($countones($past(rel_en_i)))));

   // R7: flush withholds the grant.
   p_flush_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |-> !can_alloc_o);

   // R3: the free count never exceeds the queue depth.
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((tail_q - head_q) <= (PW + 1)'(DEPTH)));

   // R3: a grant never exceeds the free entries.
   p_grant_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      can_alloc_o |-> ((PW + 1)'($countones(alloc_req_i)) <= (tail_q - head_q)));

   // R8: two granted slots never share an index.
   for (genvar a = 0; a < SLOTS; a++) begin : g_a
      for (genvar b = a + 1; b < SLOTS; b++) begin : g_b
         p_distinct_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (can_alloc_o && alloc_req_i[a] && alloc_req_i[b])
            |-> (alloc_idx_o[a] != alloc_idx_o[b]));
      end
   end

endmodule

bind preg_free_list pfl_checker #(
   .NUM_PREGS (NUM_PREGS),
   .ARCH_REGS (ARCH_REGS),
   .SLOTS     (SLOTS),
   .RELS      (RELS)
) u_pfl_chk (.*);

// File: tb/preg_free_list_test.sv
module preg_free_list_test;

   localparam int NP = 64;
   localparam int AR = 32;
   localparam int S  = 4;
   localparam int R  = 4;
   localparam int D  = NP - AR;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst_n;
   logic              flush;
   logic [S-1:0]      req;
   logic              do_alloc;
   logic              can;
   logic [S-1:0][5:0] aidx;
   logic              walk_v;
   logic [2:0]        wcnt;
   logic [R-1:0]      ren;
   logic [R-1:0][5:0] ridx;

   preg_free_list #(
      .NUM_PREGS (NP),
      .ARCH_REGS (AR),
      .SLOTS     (S),
      .RELS      (R)
   ) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush_i      (flush),
      .alloc_req_i  (req),
      .do_alloc_i   (do_alloc),
      .can_alloc_o  (can),
      .alloc_idx_o  (aidx),
      .walk_valid_i (walk_v),
      .walk_cnt_i   (wcnt),
      .rel_en_i     (ren),
      .rel_idx_i    (ridx)
   );

   // Reference model
   int mq[D];
   int mh, mt;
   bit live[NP];
   int held[$];
   int total_alloc;

   int checks, fails;
   bit done;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle();
      req = '0; do_alloc = 1'b0; flush = 1'b0;
      walk_v = 1'b0; wcnt = '0; ren = '0; ridx = '0;
   endtask

   // Commit slots release the oldest held indices in slot order.
   task automatic rel_set(input logic [R-1:0] en);
      ren = en;
      for (int j = 0; j < R; j++) begin
         if (en[j]) ridx[j] = 6'(held.pop_front());
      end
   endtask

   // One cycle: check outputs mid-cycle, then advance the model after the edge.
   task automatic step(input string tag);
      int pc; int fr; bit ec; bit fire; int off; int got[S];
      #1;
      pc = $countones(req);
      fr = mt - mh;
      ec = !flush && (fr >= pc);
      chk(can == ec, {tag, " R3 can_alloc"}, int'(can), int'(ec));
      off = 0;
      for (int i = 0; i < S; i++) begin
         got[i] = int'(aidx[i]);
         if (req[i]) begin
            chk(got[i] == mq[(mh + off) % D], {tag, " R2 slot index"}, got[i], mq[(mh + off) % D]);
            off++;
         end
      end
      fire = !walk_v && do_alloc && ec;
      @(posedge clk);
      for (int j = 0; j < R; j++) begin
         if (ren[j]) begin
            mq[mt % D] = int'(ridx[j]);
            mt++;
            live[ridx[j]] = 1'b0;
         end
      end
      if (walk_v) begin
         for (int k = 0; k < int'(wcnt); k++) live[held.pop_back()] = 1'b0;
         mh -= int'(wcnt);
      end else if (fire) begin
         for (int i = 0; i < S; i++) begin
            if (req[i]) begin
               chk(!live[got[i]], {tag, " R8 index still live"}, got[i], -1);
               live[got[i]] = 1'b1;
               held.push_back(got[i]);
               total_alloc++;
            end
         end
         mh += pc;
      end
      @(negedge clk);
   endtask

   task automatic t_reset();
      idle(); req = 4'hF;
      #1;
      for (int i = 0; i < S; i++) chk(int'(aidx[i]) == AR + i, "R1 reset fill", int'(aidx[i]), AR + i);
      chk(can == 1'b1, "R1 reset can_alloc", int'(can), 1);
      step("R1 reset");
   endtask

   task automatic t_sparse();
      idle(); req = 4'b1010; do_alloc = 1'b1;
      step("R2 sparse");
      idle(); req = 4'b0001; do_alloc = 1'b1;
      step("R2 after sparse");
      idle(); req = 4'b0001; do_alloc = 1'b1;
      step("R2 single");
   endtask

   task automatic t_hold();
      int v0;
      idle(); req = 4'hF;
      #1 v0 = int'(aidx[0]);
      step("R4 no do_alloc");
      idle(); req = 4'hF;
      #1 chk(int'(aidx[0]) == v0, "R4 head held", int'(aidx[0]), v0);
      step("R4 hold again");
   endtask

   task automatic t_flush();
      int v0;
      idle(); req = 4'hF;
      #1 v0 = int'(aidx[0]);
      idle(); req = 4'hF; do_alloc = 1'b1; flush = 1'b1; rel_set(4'b0100);
      #1 chk(can == 1'b0, "R7 flush blocks grant", int'(can), 0);
      step("R7 flush");
      idle(); req = 4'hF;
      #1 chk(int'(aidx[0]) == v0, "R7 no allocation in flush", int'(aidx[0]), v0);
      step("R7 after flush");
   endtask

   task automatic t_walk_restore();
      int snap[S];
      idle(); req = 4'hF;
      #1 for (int i = 0; i < S; i++) snap[i] = int'(aidx[i]);
      idle(); req = 4'hF; do_alloc = 1'b1; step("R9 alloc a");
      idle(); req = 4'b0111; do_alloc = 1'b1; step("R9 alloc b");
      idle(); walk_v = 1'b1; wcnt = 3'd4; step("R5 walk 4");
      idle(); walk_v = 1'b1; wcnt = 3'd3; step("R5 walk 3");
      idle(); req = 4'hF;
      #1 for (int i = 0; i < S; i++)
         chk(int'(aidx[i]) == snap[i], "R9 walk restores head", int'(aidx[i]), snap[i]);
      step("R9 restored");
   endtask

   task automatic t_walk_prio();
      int snap;
      idle(); req = 4'hF;
      #1 snap = int'(aidx[0]);
      idle(); req = 4'b0011; do_alloc = 1'b1; step("R5 pre-alloc");
      idle(); req = 4'hF; do_alloc = 1'b1; walk_v = 1'b1; wcnt = 3'd2;
      step("R5 walk with alloc");
      idle(); req = 4'hF;
      #1 chk(int'(aidx[0]) == snap, "R5 walk overrides allocation", int'(aidx[0]), snap);
      step("R5 after");
   endtask

   task automatic t_release_order();
      int r[3]; int n;
      idle(); req = 4'hF; do_alloc = 1'b1; step("R6 prefill");
      idle(); rel_set(4'b1011);
      r[0] = int'(ridx[0]); r[1] = int'(ridx[1]); r[2] = int'(ridx[3]);
      step("R6 release");
      n = mt - mh - 3;
      while (n > 0) begin
         idle(); do_alloc = 1'b1;
         req = (n >= 4) ? 4'hF : 4'((1 << n) - 1);
         n -= $countones(req);
         step("R6 drain");
      end
      idle(); req = 4'hF; do_alloc = 1'b1;
      #1 chk(can == 1'b0, "R3 too few free entries", int'(can), 0);
      step("R3 short");
      idle(); req = 4'b0111; do_alloc = 1'b1;
      #1 for (int i = 0; i < 3; i++)
         chk(int'(aidx[i]) == r[i], "R6 release order", int'(aidx[i]), r[i]);
      step("R6 reuse");
   endtask

   task automatic t_churn();
      logic [R-1:0] en; int avail;
      for (int c = 0; c < 400; c++) begin
         idle();
         req      = 4'($urandom);
         do_alloc = ($urandom % 4) != 0;
         flush    = ($urandom % 16) == 0;
         avail    = held.size() - AR;
         en       = 4'($urandom);
         for (int j = R - 1; j >= 0; j--) begin
            if ($countones(en) > avail) en[j] = 1'b0;
         end
         rel_set(en);
         step("R10 churn");
      end
      chk(total_alloc > 2 * D, "R10 pointers wrapped", total_alloc, 2 * D);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      checks = 0; fails = 0; done = 1'b0; total_alloc = 0;
      rst_n = 1'b0;
      idle();
      for (int k = 0; k < D; k++) mq[k] = AR + k;
      mh = 0; mt = D;
      for (int k = 0; k < NP; k++) live[k] = (k < AR);
      for (int k = 0; k < AR; k++) held.push_back(k);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_sparse();
      t_hold();
      t_flush();
      t_walk_restore();
      t_walk_prio();
      t_release_order();
      t_churn();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule